// File: doc/BRIEF.md
# Per-Core Power and Frequency Sequencer

This block takes one or more processor cores through power-down and clock-frequency changes, and brings them back. Software programs a small group of registers for each core. The registers set which transition to request, which conditions the sequencer must wait for, which events may wake the core, and the address the core restarts from. The transition itself does not begin when software writes the request. It begins when the core enters its wait-for-interrupt state while idle-waiting is enabled. This lets software arm a request and then halt the core, and the hardware completes the job.

For a power-down, the sequencer can also wait for the core's snoop queue to drain. It then raises the core power-down request, and an L2 power-down request where that is allowed. It holds both until an enabled wake source arrives. For a frequency change, it raises a switch request toward the clock logic and waits for a one-cycle done pulse. It then records completion in an event register, which can raise an interrupt. Every core has its own sequencer, and the sequencers work independently of one another. The register port is a plain single-cycle memory-mapped interface, and reads return their data combinationally.

Top module: `cpu_pm_seq`

## Requirements
- R1: After reset, every output is low, `boot_addr_o` is zero, and every register reads as zero.
- R2: Core n (numbered from 0) has its register group at base 0x100·(n+1), at these offsets:
  - control at +0x04: bit 16 requests power-down, bit 18 requests a frequency switch, bit 20 requests L2 power-down.
  - power-down control at +0x08: bit 0 disables the hardware's snoop-wait skip.
  - status/mask at +0x0C: bit 16 enables idle wait, bit 17 enables snoop wait, bits 20, 21 and 22 enable IRQ, FIQ and debug wake, bits 24 and 25 mask IRQ and FIQ.
  - event at +0x20: bit 1 signals completion, bit 17 masks the completion interrupt.
  - boot address at +0x24: all 32 bits.
  - A fabric word at 0x004 uses bit 20 to allow L2 power-down.
  - Every other bit reads as zero.
- R3: A read from an unmapped offset returns zero, and a write to it changes nothing. Unmapped offsets include the register groups beyond the configured core count.
- R4: `core_pd_o` rises only when all three hold: control bit 16 is set, status bit 16 is set, and the core has raised `core_wfi_i`. It stays high until a wake event.
- R5: The snoop-queue wait is applied only when status bit 17 and power-down control bit 0 are both set. When it applies, `core_pd_o` waits for `snoop_empty_i`. Otherwise the wait is skipped.
- R6: While a core is powered down, only a wake input enabled by status bits 20, 21 or 22 ends the power-down. `core_pd_o` falls on the clock edge after the wake input is seen. Afterwards, control bit 16 reads as zero.
- R7: `l2_pd_o` is high only while `core_pd_o` is high, control bit 20 is set, and fabric bit 20 is set.
- R8: A frequency switch starts only on `core_wfi_i` while status bit 16 is set. `fs_req_o` stays high until a `fs_done_i` pulse, then drops, and control bit 18 reads as zero.
- R9: When a switch completes, event bit 1 is set. `done_irq_o` equals event bit 1 AND NOT event bit 17.
- R10: Software clears event bit 1 by writing 0 to it. Writing 1 to event bit 1 never sets it.
- R11: `irq_mask_o` and `fiq_mask_o` follow status bits 24 and 25.
- R12: `boot_addr_o` slice n presents core n's boot-address register.
- R13: If power-down and switch requests are both armed, power-down goes first, and `core_pd_o` and `fs_req_o` are never high together. The switch still pending runs after the wake.
- R14: The activity of one core never changes another core's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| core_wfi_i | input | NCORES | Core is in wait-for-interrupt |
| snoop_empty_i | input | NCORES | Core snoop queue is empty |
| irq_i | input | NCORES | IRQ wake source |
| fiq_i | input | NCORES | FIQ wake source |
| dbg_i | input | NCORES | Debug wake source |
| fs_done_i | input | NCORES | One-cycle frequency-switch done |
| core_pd_o | output | NCORES | Core power-down request |
| l2_pd_o | output | NCORES | L2 power-down request |
| fs_req_o | output | NCORES | Frequency-switch request |
| irq_mask_o | output | NCORES | IRQ masked toward core |
| fiq_mask_o | output | NCORES | FIQ masked toward core |
| done_irq_o | output | NCORES | Switch-completion interrupt |
| boot_addr_o | output | 32·NCORES | Restart address, core n in bits [32n+31:32n] |

## Verification
The bench arms requests while the core is not yet idle. A design that started on the register write would raise `core_pd_o` or `fs_req_o` early. It holds the snoop queue full under both settings of the skip-disable bit. A design with the gating wrong would either power down too early or hang. It pulses a wake source that is not enabled while the core is down, and a design that ignored the enables would wake on it. It arms both requests at once, which exposes a wrong priority or two requests raised together. It writes 1 to the completion bit, which exposes a register that software can set. It also accesses group offsets beyond the core count, which exposes an address decoder that wraps around.

// File: rtl/cpu_pm_pkg.sv
package cpu_pm_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WAIT_IDLE,
        ST_WAIT_SNOOP,
        ST_DOWN,
        ST_FREQ,
        ST_WAKE
    } pm_state_e;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_PDCTL,
        RS_STAT,
        RS_EVENT,
        RS_BOOT
    } reg_sel_e;

    // offsets inside a core group (low address byte)
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_PDCTL = 8'h08;
    localparam logic [7:0] OFS_STAT  = 8'h0C;
    localparam logic [7:0] OFS_EVENT = 8'h20;
    localparam logic [7:0] OFS_BOOT  = 8'h24;
    localparam int unsigned FAB_ADDR = 32'h004;

    // bit positions
    localparam int unsigned B_PD_REQ     = 16;
    localparam int unsigned B_FS_REQ     = 18;
    localparam int unsigned B_L2_REQ     = 20;
    localparam int unsigned B_NO_SKIP    = 0;
    localparam int unsigned B_IDLE_WAIT  = 16;
    localparam int unsigned B_SNOOP_WAIT = 17;
    localparam int unsigned B_WAKE_IRQ   = 20;
    localparam int unsigned B_WAKE_FIQ   = 21;
    localparam int unsigned B_WAKE_DBG   = 22;
    localparam int unsigned B_MASK_IRQ   = 24;
    localparam int unsigned B_MASK_FIQ   = 25;
    localparam int unsigned B_DONE       = 1;
    localparam int unsigned B_DONE_MASK  = 17;
    localparam int unsigned B_FAB_L2     = 20;

    typedef struct packed {
        pm_state_e   st;
        logic        pd_req;
        logic        fs_req;
        logic        l2_req;
        logic        no_skip;
        logic        idle_wait;
        logic        snoop_wait;
        logic [2:0]  wake_en;   // [0] irq, [1] fiq, [2] dbg
        logic        irq_mask;
        logic        fiq_mask;
        logic        done;
        logic        done_mask;
        logic [31:0] boot;
    } core_regs_t;

endpackage

// File: rtl/cpu_pm_decode.sv
module cpu_pm_decode
    import cpu_pm_pkg::*;
#(
    parameter int NCORES = 2,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCORES-1:0] core_hit,
    output reg_sel_e          sel,
    output logic              fab_hit
);

    localparam int BLK_W = ADDR_W - 8;

    logic [BLK_W-1:0] blk;

    always_comb begin
        blk = addr[ADDR_W-1:8];
        unique case (addr[7:0])
            OFS_CTRL:  sel = RS_CTRL;
            OFS_PDCTL: sel = RS_PDCTL;
            OFS_STAT:  sel = RS_STAT;
            OFS_EVENT: sel = RS_EVENT;
            OFS_BOOT:  sel = RS_BOOT;
            default:   sel = RS_NONE;
        endcase
        fab_hit = (addr == ADDR_W'(FAB_ADDR));
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_hit
        assign core_hit[c] = (blk == BLK_W'(c + 1)) && (sel != RS_NONE);
    end

endmodule

// File: rtl/cpu_pm_wake.sv
module cpu_pm_wake (
    input  logic       irq,
    input  logic       fiq,
    input  logic       dbg,
    input  logic [2:0] en,
    output logic       wake
);

    always_comb begin
        wake = |({dbg, fiq, irq} & en);
    end

endmodule

// File: rtl/cpu_pm_core.sv
module cpu_pm_core
    import cpu_pm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output logic [31:0] rd_data,
    input  logic        fab_en,
    input  logic        wfi,
    input  logic        snoop_empty,
    input  logic        irq,
    input  logic        fiq,
    input  logic        dbg,
    input  logic        fs_done,
    output logic        pd_o,
    output logic        l2_o,
    output logic        fs_o,
    output logic        irq_mask_o,
    output logic        fiq_mask_o,
    output logic        done_irq_o,
    output logic [31:0] boot_o
);

    core_regs_t q, d;
    logic       wake;
    logic       armed;
    logic       snoop_gate;

    cpu_pm_wake u_wake (
        .irq  (irq),
        .fiq  (fiq),
        .dbg  (dbg),
        .en   (q.wake_en),
        .wake (wake)
    );

    always_comb begin
        d          = q;
        armed      = q.idle_wait && (q.pd_req || q.fs_req);
        snoop_gate = q.snoop_wait && q.no_skip;

        // software writes
        if (wr_en) begin
            unique case (sel)
                RS_CTRL: begin
                    d.pd_req = wdata[B_PD_REQ];
                    d.fs_req = wdata[B_FS_REQ];
                    d.l2_req = wdata[B_L2_REQ];
                end
                RS_PDCTL: d.no_skip = wdata[B_NO_SKIP];
                RS_STAT: begin
                    d.idle_wait  = wdata[B_IDLE_WAIT];
                    d.snoop_wait = wdata[B_SNOOP_WAIT];
                    d.wake_en    = {wdata[B_WAKE_DBG], wdata[B_WAKE_FIQ], wdata[B_WAKE_IRQ]};
                    d.irq_mask   = wdata[B_MASK_IRQ];
                    d.fiq_mask   = wdata[B_MASK_FIQ];
                end
                RS_EVENT: begin
                    d.done      = q.done & wdata[B_DONE];
                    d.done_mask = wdata[B_DONE_MASK];
                end
                RS_BOOT: d.boot = wdata;
                default: ;
            endcase
        end

        // sequencer; hardware updates take precedence over software
        unique case (q.st)
            ST_RUN: begin
                if (armed) d.st = ST_WAIT_IDLE;
            end
            ST_WAIT_IDLE: begin
                if (!armed) begin
                    d.st = ST_RUN;
                end else if (wfi) begin
                    if (q.pd_req) d.st = snoop_gate ? ST_WAIT_SNOOP : ST_DOWN;
                    else          d.st = ST_FREQ;
                end
            end
            ST_WAIT_SNOOP: begin
                if (snoop_empty) d.st = ST_DOWN;
            end
            ST_DOWN: begin
                if (wake) d.st = ST_WAKE;
            end
            ST_WAKE: begin
                d.pd_req = 1'b0;
                d.st     = ST_RUN;
            end
            ST_FREQ: begin
                if (fs_done) begin
                    d.done   = 1'b1;
                    d.fs_req = 1'b0;
                    d.st     = ST_RUN;
                end
            end
            default: d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            RS_CTRL: begin
                rd_data[B_PD_REQ] = q.pd_req;
                rd_data[B_FS_REQ] = q.fs_req;
                rd_data[B_L2_REQ] = q.l2_req;
            end
            RS_PDCTL: rd_data[B_NO_SKIP] = q.no_skip;
            RS_STAT: begin
                rd_data[B_IDLE_WAIT]  = q.idle_wait;
                rd_data[B_SNOOP_WAIT] = q.snoop_wait;
                rd_data[B_WAKE_IRQ]   = q.wake_en[0];
                rd_data[B_WAKE_FIQ]   = q.wake_en[1];
                rd_data[B_WAKE_DBG]   = q.wake_en[2];
                rd_data[B_MASK_IRQ]   = q.irq_mask;
                rd_data[B_MASK_FIQ]   = q.fiq_mask;
            end
            RS_EVENT: begin
                rd_data[B_DONE]      = q.done;
                rd_data[B_DONE_MASK] = q.done_mask;
            end
            RS_BOOT: rd_data = q.boot;
            default: ;
        endcase
    end

    always_comb begin
        pd_o       = (q.st == ST_DOWN);
        l2_o       = pd_o && q.l2_req && fab_en;
        fs_o       = (q.st == ST_FREQ);
        irq_mask_o = q.irq_mask;
        fiq_mask_o = q.fiq_mask;
        done_irq_o = q.done && !q.done_mask;
        boot_o     = q.boot;
    end

endmodule

// File: rtl/cpu_pm_seq.sv
module cpu_pm_seq
    import cpu_pm_pkg::*;
#(
    parameter int NCORES = 2,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NCORES-1:0]    core_wfi_i,
    input  logic [NCORES-1:0]    snoop_empty_i,
    input  logic [NCORES-1:0]    irq_i,
    input  logic [NCORES-1:0]    fiq_i,
    input  logic [NCORES-1:0]    dbg_i,
    input  logic [NCORES-1:0]    fs_done_i,
    output logic [NCORES-1:0]    core_pd_o,
    output logic [NCORES-1:0]    l2_pd_o,
    output logic [NCORES-1:0]    fs_req_o,
    output logic [NCORES-1:0]    irq_mask_o,
    output logic [NCORES-1:0]    fiq_mask_o,
    output logic [NCORES-1:0]    done_irq_o,
    output logic [NCORES*32-1:0] boot_addr_o
);

    logic [NCORES-1:0] core_hit;
    reg_sel_e          sel;
    logic              fab_hit;
    logic              fab_q, fab_d;
    logic [31:0]       core_rd [NCORES];

    cpu_pm_decode #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .core_hit (core_hit),
        .sel      (sel),
        .fab_hit  (fab_hit)
    );

    always_comb begin
        fab_d = fab_q;
        if (bus_sel && bus_wr && fab_hit) fab_d = bus_wdata[B_FAB_L2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fab_q <= 1'b0;
        else        fab_q <= fab_d;
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        cpu_pm_core u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bus_sel && bus_wr && core_hit[c]),
            .sel         (sel),
            .wdata       (bus_wdata),
            .rd_data     (core_rd[c]),
            .fab_en      (fab_q),
            .wfi         (core_wfi_i[c]),
            .snoop_empty (snoop_empty_i[c]),
            .irq         (irq_i[c]),
            .fiq         (fiq_i[c]),
            .dbg         (dbg_i[c]),
            .fs_done     (fs_done_i[c]),
            .pd_o        (core_pd_o[c]),
            .l2_o        (l2_pd_o[c]),
            .fs_o        (fs_req_o[c]),
            .irq_mask_o  (irq_mask_o[c]),
            .fiq_mask_o  (fiq_mask_o[c]),
            .done_irq_o  (done_irq_o[c]),
            .boot_o      (boot_addr_o[c*32 +: 32])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (fab_hit) bus_rdata[B_FAB_L2] = fab_q;
            for (int c = 0; c < NCORES; c++) begin
                if (core_hit[c]) bus_rdata = bus_rdata | core_rd[c];
            end
        end
    end

endmodule

// File: rtl/cpu_pm_seq_chk.sv
module cpu_pm_seq_chk #(
    parameter int NCORES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCORES-1:0] core_wfi_i,
    input logic [NCORES-1:0] snoop_empty_i,
    input logic [NCORES-1:0] irq_i,
    input logic [NCORES-1:0] fiq_i,
    input logic [NCORES-1:0] dbg_i,
    input logic [NCORES-1:0] fs_done_i,
    input logic [NCORES-1:0] core_pd_o,
    input logic [NCORES-1:0] l2_pd_o,
    input logic [NCORES-1:0] fs_req_o
);

    for (genvar i = 0; i < NCORES; i++) begin : g_chk
        // R4: power-down begins only after the idle or snoop handshake
        a_r4_pd_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_pd_o[i]) |-> ($past(core_wfi_i[i]) || $past(snoop_empty_i[i])));

        // R6: power-down ends only on a wake input
        a_r6_wake_ends_pd: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_pd_o[i]) |-> ($past(irq_i[i]) || $past(fiq_i[i]) || $past(dbg_i[i])));

        // R7: L2 request only inside a core power-down
        a_r7_l2_inside_pd: assert property (@(posedge clk) disable iff (!rst_n)
            l2_pd_o[i] |-> core_pd_o[i]);

        // R8: switch starts on idle and ends on done
        a_r8_fs_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fs_req_o[i]) |-> $past(core_wfi_i[i]));

        a_r8_fs_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
            (fs_req_o[i] && fs_done_i[i]) |=> !fs_req_o[i]);

        a_r8_fs_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (fs_req_o[i] && !fs_done_i[i]) |=> fs_req_o[i]);

        // R13: never both requests together
        a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(core_pd_o[i] && fs_req_o[i]));
    end

endmodule

bind cpu_pm_seq cpu_pm_seq_chk #(.NCORES(NCORES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_wfi_i    (core_wfi_i),
    .snoop_empty_i (snoop_empty_i),
    .irq_i         (irq_i),
    .fiq_i         (fiq_i),
    .dbg_i         (dbg_i),
    .fs_done_i     (fs_done_i),
    .core_pd_o     (core_pd_o),
    .l2_pd_o       (l2_pd_o),
    .fs_req_o      (fs_req_o)
);

// File: tb/cpu_pm_seq_bench.sv
module cpu_pm_seq_bench;

    localparam int NC = 2;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   wfi = '0, snp = '0, irq = '0, fiq = '0, dbg = '0, fsd = '0;
    logic [NC-1:0]   pd, l2, fs, im, fm, dirq;
    logic [NC*32-1:0] boot;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cpu_pm_seq #(.NCORES(NC), .ADDR_W(AW)) u_cpu_pm_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_wfi_i(wfi), .snoop_empty_i(snp), .irq_i(irq), .fiq_i(fiq),
        .dbg_i(dbg), .fs_done_i(fsd),
        .core_pd_o(pd), .l2_pd_o(l2), .fs_req_o(fs),
        .irq_mask_o(im), .fiq_mask_o(fm), .done_irq_o(dirq),
        .boot_addr_o(boot)
    );

    function automatic logic [AW-1:0] ra(input int core, input int ofs);
        return AW'((core + 1) * 32'h100 + ofs);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_irq(input int c);
        @(negedge clk); irq[c] = 1'b1;
        @(negedge clk); irq[c] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pd", 32'(pd), 0);
        chk("R1 l2", 32'(l2), 0);
        chk("R1 fs", 32'(fs), 0);
        chk("R1 masks", 32'({im, fm, dirq}), 0);
        chk("R1 boot", boot[31:0] | boot[63:32], 0);
        rd("R1 ctrl0", ra(0, 4), 0);
        rd("R1 stat1", ra(1, 12), 0);
        rd("R1 boot0", ra(0, 36), 0);
        rd("R1 fabric", 12'h004, 0);
    endtask

    task automatic t_regmap();
        wr(ra(1, 12), 32'hFFFF_FFFF);
        rd("R2 stat", ra(1, 12), 32'h0373_0000);
        chk("R11 irq mask", 32'(im[1]), 1);
        chk("R11 fiq mask", 32'(fm[1]), 1);
        wr(ra(1, 12), 32'h0100_0000);
        chk("R11 irq only", 32'({im[1], fm[1]}), 32'b10);
        wr(ra(1, 12), 0);
        chk("R11 cleared", 32'({im[1], fm[1]}), 0);
        wr(ra(1, 4), 32'hFFFF_FFFF);
        rd("R2 ctrl", ra(1, 4), 32'h0015_0000);
        wr(ra(1, 4), 0);
        wr(ra(1, 8), 32'hFFFF_FFFF);
        rd("R2 pdctl", ra(1, 8), 32'h0000_0001);
        wr(ra(1, 8), 0);
        wr(ra(1, 32), 32'hFFFF_FFFF);
        rd("R10 event sw cannot set", ra(1, 32), 32'h0002_0000);
        wr(ra(1, 32), 0);
        wr(ra(1, 36), 32'hDEAD_BEEF);
        rd("R2 boot", ra(1, 36), 32'hDEAD_BEEF);
        chk("R12 boot out core1", boot[63:32], 32'hDEAD_BEEF);
        chk("R12 boot out core0", boot[31:0], 0);
        wr(12'h004, 32'hFFFF_FFFF);
        rd("R2 fabric", 12'h004, 32'h0010_0000);
        wr(12'h004, 0);
    endtask

    task automatic t_unmapped();
        wr(12'h110, 32'hFFFF_FFFF);
        wr(12'h304, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd("R3 gap", 12'h110, 0);
        rd("R3 beyond count", 12'h304, 0);
        rd("R3 zero", 12'h000, 0);
        rd("R3 ctrl0 untouched", ra(0, 4), 0);
        rd("R3 ctrl1 untouched", ra(1, 4), 0);
        rd("R3 fabric untouched", 12'h004, 0);
    endtask

    task automatic t_pd_basic();
        wr(ra(0, 12), 32'h0011_0000);
        wr(ra(0, 4), 32'h0001_0000);
        cyc(8);
        chk("R4 no pd before wfi", 32'(pd[0]), 0);
        wfi[0] = 1'b1;
        cyc(3);
        chk("R4 pd after wfi", 32'(pd[0]), 1);
        chk("R14 core1 idle", 32'({pd[1], fs[1]}), 0);
        @(negedge clk); fiq[0] = 1'b1;
        @(negedge clk); fiq[0] = 1'b0;
        cyc(3);
        chk("R6 disabled wake ignored", 32'(pd[0]), 1);
        pulse_irq(0);
        chk("R6 pd falls after wake", 32'(pd[0]), 0);
        cyc(2);
        rd("R6 pd bit cleared", ra(0, 4), 0);
        wfi[0] = 1'b0;
        wr(ra(0, 12), 0);
    endtask

    task automatic t_snoop();
        wr(ra(0, 8), 1);
        wr(ra(0, 12), 32'h0013_0000);
        wr(ra(0, 4), 32'h0001_0000);
        wfi[0] = 1'b1;
        cyc(8);
        chk("R5 waits for snoop", 32'(pd[0]), 0);
        snp[0] = 1'b1;
        cyc(3);
        chk("R5 pd after snoop empty", 32'(pd[0]), 1);
        pulse_irq(0);
        wfi[0] = 1'b0; snp[0] = 1'b0;
        cyc(2);
        wr(ra(0, 8), 0);
        wr(ra(0, 4), 32'h0001_0000);
        wfi[0] = 1'b1;
        cyc(4);
        chk("R5 snoop wait skipped", 32'(pd[0]), 1);
        pulse_irq(0);
        wfi[0] = 1'b0;
        cyc(2);
        wr(ra(0, 12), 0);
    endtask

    task automatic t_l2();
        wr(ra(0, 12), 32'h0011_0000);
        wr(ra(0, 4), 32'h0011_0000);
        wfi[0] = 1'b1;
        cyc(4);
        chk("R7 pd on", 32'(pd[0]), 1);
        chk("R7 l2 blocked by fabric", 32'(l2[0]), 0);
        wr(12'h004, 32'h0010_0000);
        cyc(1);
        chk("R7 l2 with fabric", 32'(l2[0]), 1);
        pulse_irq(0);
        cyc(1);
        chk("R7 l2 off after wake", 32'({pd[0], l2[0]}), 0);
        wfi[0] = 1'b0;
        wr(12'h004, 0);
        wr(ra(0, 4), 0);
        wr(ra(0, 12), 0);
    endtask

    task automatic t_fs();
        wr(ra(0, 12), 32'h0001_0000);
        wr(ra(0, 4), 32'h0004_0000);
        cyc(8);
        chk("R8 no switch before wfi", 32'(fs[0]), 0);
        wfi[0] = 1'b1;
        cyc(3);
        chk("R8 switch on wfi", 32'(fs[0]), 1);
        cyc(5);
        chk("R8 held until done", 32'(fs[0]), 1);
        @(negedge clk); fsd[0] = 1'b1;
        @(negedge clk); fsd[0] = 1'b0;
        chk("R8 drops after done", 32'(fs[0]), 0);
        wfi[0] = 1'b0;
        rd("R9 done bit", ra(0, 32), 32'h0000_0002);
        chk("R9 done irq", 32'(dirq[0]), 1);
        rd("R8 fs bit cleared", ra(0, 4), 0);
        wr(ra(0, 32), 32'h0002_0002);
        chk("R9 irq masked", 32'(dirq[0]), 0);
        rd("R9 done kept", ra(0, 32), 32'h0002_0002);
        wr(ra(0, 32), 32'h0002_0000);
        rd("R10 cleared by zero", ra(0, 32), 32'h0002_0000);
        wr(ra(0, 32), 32'h0000_0002);
        rd("R10 one does not set", ra(0, 32), 0);
        chk("R10 irq low", 32'(dirq[0]), 0);
        wr(ra(0, 12), 0);
    endtask

    task automatic t_prio();
        wr(ra(0, 12), 32'h0011_0000);
        wr(ra(0, 4), 32'h0005_0000);
        wfi[0] = 1'b1;
        cyc(4);
        chk("R13 pd first", 32'({pd[0], fs[0]}), 32'b10);
        chk("R14 core1 untouched", 32'({pd[1], fs[1], l2[1], dirq[1]}), 0);
        pulse_irq(0);
        cyc(3);
        chk("R13 pending switch runs", 32'({pd[0], fs[0]}), 32'b01);
        @(negedge clk); fsd[0] = 1'b1;
        @(negedge clk); fsd[0] = 1'b0;
        wfi[0] = 1'b0;
        rd("R13 both bits cleared", ra(0, 4), 0);
        wr(ra(0, 32), 0);
        wr(ra(0, 12), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regmap();
        t_unmapped();
        t_pd_basic();
        t_snoop();
        t_l2();
        t_fs();
        t_prio();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule